// File: doc/BRIEF.md
# Windowed Write-Once Option Register

An 8-bit configuration register on a simple synchronous register bus. It holds the settings that steer several neighbouring blocks: converter power-up, converter clock source, interrupt edge mode, a delay applied on wake from stop, clock-monitor enable and a two-bit rate select. Each field drives its own output pin.

The bits fall into two protection classes. Free bits take any write at any time. Guarded bits take only the first normal-mode write, and only while a short window after reset is still open. When the window has closed, or once a guarded write has landed, the guarded bits are frozen until the next reset. Raising the special-mode input, used for test or bootstrap operation, removes every restriction. Software that uses both stop and the clock monitor should clear the clock-monitor enable before stopping, so that a halted clock does not trigger a reset.

Top module: `cfg_option_reg`

## Requirements
- R1: After reset the register reads 0x10, so only the stop-exit delay enable (bit 4) is set.
- R2: Free bits 7 (converter power-up), 6 (converter clock select) and 3 (clock-monitor enable) take every write, in either mode and at any cycle.
- R3: In normal mode (special input low), the first write to guarded bits 5, 4, 1 and 0 is accepted when it lands on clock edge 0 to 63, counting from the first edge after reset release as edge 0.
- R4: In normal mode, a write that lands on edge 64 or later leaves the guarded bits unchanged.
- R5: In normal mode, a second write inside the window leaves the guarded bits unchanged but still updates the free bits.
- R6: With the special input high, the guarded bits take every write, at any cycle after reset and any number of times.
- R7: Bit 2 is not stored; it reads as zero whatever is written.
- R8: While select and read are both high, read data shows the stored value in the same cycle; otherwise read data is zero.
- R9: Outputs follow the stored bits: bit 7 converter power-up, bit 6 clock select, bit 5 interrupt edge mode (0 low level, 1 falling edge only), bit 4 stop-exit delay, bit 3 clock-monitor enable, bits 1:0 rate select.
- R10: A special-mode write does not use up the single normal-mode guarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| special_i | input | 1 | Special test/bootstrap mode, lifts all protection |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable, acts on the rising edge when selected |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| adc_pwr_o | output | 1 | Converter power-up |
| clk_sel_o | output | 1 | Converter clock select |
| irq_edge_o | output | 1 | Interrupt edge mode |
| stop_dly_o | output | 1 | Stop-exit delay enable |
| clkmon_en_o | output | 1 | Clock-monitor enable |
| rate_sel_o | output | 2 | Rate select |

## Verification
The bench builds the block with its default parameters: an 8-bit register and a 64-edge window. Because that window is short, the bench can reset the block for each write edge from 0 to 70. This reaches edges 63 and 64 and a second write in every open-window position. In special mode it also sweeps all 256 write values long after the window has closed.

// File: rtl/cfg_option_pkg.sv
package cfg_option_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned WINDOW_EDGES = 64;
  localparam logic [7:0]  RESET_VALUE  = 8'h10;
  localparam logic [7:0]  FREE_MASK    = 8'hC8;
  localparam logic [7:0]  GUARD_MASK   = 8'h33;

  localparam int unsigned BIT_ADC_PWR  = 7;
  localparam int unsigned BIT_CLK_SEL  = 6;
  localparam int unsigned BIT_IRQ_EDGE = 5;
  localparam int unsigned BIT_STOP_DLY = 4;
  localparam int unsigned BIT_CLKMON   = 3;
  localparam int unsigned BIT_RATE_LO  = 0;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_FREE  = 2'd1,
    CLS_GUARD = 2'd2
  } bit_class_e;
endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
  parameter int unsigned WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open_o
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign win_open_o = (cnt_q < LIMIT);

  assert_window_stays_closed_R4: assert property (
    @(posedge clk) disable iff (!rst_n) !win_open_o |=> !win_open_o);
endmodule

// File: rtl/cfg_guard_lock.sv
module cfg_guard_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic special_i,
  input  logic win_open_i,
  output logic guard_en_o
);
  logic locked_q, locked_d;
  logic lock_set;

  always_comb begin
    lock_set   = wr_i && !special_i && win_open_i;
    locked_d   = locked_q || lock_set;
    guard_en_o = wr_i && (special_i || (win_open_i && !locked_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (lock_set) begin
      locked_q <= locked_d;
    end
  end

  assert_lock_sticky_R5: assert property (
    @(posedge clk) disable iff (!rst_n) locked_q |=> locked_q);
  assert_special_not_locking_R10: assert property (
    @(posedge clk) disable iff (!rst_n) (special_i && !locked_q) |=> !locked_q);
endmodule

// File: rtl/cfg_bit_cell.sv
module cfg_bit_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb q_d = d_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= RST_VAL;
    end else if (en_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cfg_option_reg.sv
module cfg_option_reg
  import cfg_option_pkg::*;
#(
  parameter int unsigned       WINDOW  = WINDOW_EDGES,
  parameter logic [REG_W-1:0]  RST_VAL = RESET_VALUE,
  parameter logic [REG_W-1:0]  FREE_M  = FREE_MASK,
  parameter logic [REG_W-1:0]  GUARD_M = GUARD_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             adc_pwr_o,
  output logic             clk_sel_o,
  output logic             irq_edge_o,
  output logic             stop_dly_o,
  output logic             clkmon_en_o,
  output logic [1:0]       rate_sel_o
);
  localparam logic [REG_W-1:0] IMPL_M = FREE_M | GUARD_M;

  logic             wr;
  logic             win_open;
  logic             guard_en;
  logic [REG_W-1:0] value;
  logic             unused_wbits;

  assign wr           = sel_i && we_i;
  assign unused_wbits = ^(wdata_i & ~IMPL_M);

  cfg_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_open_o (win_open)
  );

  cfg_guard_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr),
    .special_i  (special_i),
    .win_open_i (win_open),
    .guard_en_o (guard_en)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam bit_class_e CLS = FREE_M[i]  ? CLS_FREE  :
                                 GUARD_M[i] ? CLS_GUARD : CLS_NONE;
    if (CLS == CLS_FREE) begin : g_free
      cfg_bit_cell #(.RST_VAL(RST_VAL[i])) u_cell (
        .clk(clk), .rst_n(rst_n), .en_i(wr), .d_i(wdata_i[i]), .q_o(value[i]));
    end else if (CLS == CLS_GUARD) begin : g_guard
      cfg_bit_cell #(.RST_VAL(RST_VAL[i])) u_cell (
        .clk(clk), .rst_n(rst_n), .en_i(guard_en), .d_i(wdata_i[i]), .q_o(value[i]));
    end else begin : g_none
      assign value[i] = 1'b0;
    end
  end

  assign rdata_o     = (sel_i && rd_i) ? value : '0;
  assign adc_pwr_o   = value[BIT_ADC_PWR];
  assign clk_sel_o   = value[BIT_CLK_SEL];
  assign irq_edge_o  = value[BIT_IRQ_EDGE];
  assign stop_dly_o  = value[BIT_STOP_DLY];
  assign clkmon_en_o = value[BIT_CLKMON];
  assign rate_sel_o  = value[BIT_RATE_LO +: 2];

  assert_guard_frozen_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!special_i && !win_open) |=> $stable(value & GUARD_M));
  assert_free_follows_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr |=> ((value & FREE_M) == ($past(wdata_i) & FREE_M)));
  assert_special_write_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr && special_i) |=> ((value & GUARD_M) == ($past(wdata_i) & GUARD_M)));
  assert_unimpl_zero_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (value & ~IMPL_M) == '0);
  assert_idle_read_zero_R8: assert property (
    @(posedge clk) disable iff (!rst_n) !(sel_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/cfg_option_reg_test.sv
module cfg_option_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special = 1'b0;
  logic       sel = 1'b0, we = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       adc_pwr, clk_sel, irq_edge, stop_dly, clkmon_en;
  logic [1:0] rate_sel;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_option_reg uut (
    .clk(clk), .rst_n(rst_n), .special_i(special), .sel_i(sel), .we_i(we),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .adc_pwr_o(adc_pwr),
    .clk_sel_o(clk_sel), .irq_edge_o(irq_edge), .stop_dly_o(stop_dly),
    .clkmon_en_o(clkmon_en), .rate_sel_o(rate_sel));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // leaves the bench at a falling edge with reset just released
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    special = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] d);
    sel = 1'b1; we = 1'b1; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd_check(input string req, input logic [7:0] exp);
    sel = 1'b1; rd = 1'b1;
    #1;
    check(req, rdata, exp);
    sel = 1'b0; rd = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] pins();
    return {adc_pwr, clk_sel, irq_edge, stop_dly, clkmon_en, 1'b0, rate_sel};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset value, R9 pins
    do_reset();
    rd_check("R1", 8'h10);
    check("R9", pins(), 8'h10);
    // R8 no read strobe -> zero
    #1; check("R8", rdata, 8'h00);

    // sweep write edge 0..70
    for (int k = 0; k <= 70; k++) begin
      do_reset();
      repeat (k) @(negedge clk);
      wr(8'hFF);
      if (k < 64) begin
        rd_check("R3", 8'hFB);
        check("R9", pins(), 8'hFB);
        if (k < 63) begin
          wr(8'h00);
          rd_check("R5", 8'h33);
        end
      end else begin
        rd_check("R4", 8'hD8);
        check("R2", pins(), 8'hD8);
      end
    end

    // R6 special mode long after reset, all values
    do_reset();
    repeat (200) @(negedge clk);
    special = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      rd_check("R6", 8'(v) & 8'hFB);
    end
    check("R7", rdata, 8'h00);
    wr(8'hFF);
    special = 1'b0;
    wr(8'h00);
    rd_check("R4", 8'h33);

    // R10 special write then normal write in window
    do_reset();
    special = 1'b1;
    wr(8'h00);
    special = 1'b0;
    wr(8'h27);
    rd_check("R10", 8'h23);
    wr(8'h00);
    rd_check("R5", 8'h23);
    wr(8'h04);
    rd_check("R7", 8'h23 & 8'h33);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule